// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block is a non-blocking time-division-multiplexed switch. Several serial input lanes each carry a fixed number of 8-bit channels per frame. Every received channel is written into a data store that keeps three frame pages. Each output lane is then built slot by slot. For every output slot, a connection entry names the input lane and channel to copy. The entry can also replace the switched byte with a byte written by the host, or release the lane for that slot.

A host write port programs one connection entry per cycle. Each entry picks one of two delay modes:

- Minimum delay forwards a byte in the same frame when that is possible.
- Constant delay holds every byte of an input frame for exactly two frames. Channels that belong together therefore leave in the same output frame.

Host writes are staged and applied together at the next frame boundary, so an output frame never mixes old and new connections.

The lane rate is set by the channel count: 32, 64 or 128 channels for the three supported rates. The master clock runs at twice the bit rate. The lane and channel counts must be powers of two, with at most 16 lanes and 128 channels.

Top module: `tsi_switch`

## Requirements
- R1: Framing.
  - When `fp_n` is sampled low at a clock edge, the next cycle is the first cycle of channel 0, and the frame counter restarts there.
  - Channel c occupies frame cycles 16c to 16c+15. Each bit lasts two cycles, most significant bit first.
  - An input bit is taken in the first cycle of its pair. An output bit holds its value for both cycles of its pair.
- R2: From reset, every bit of `tx_oe` is low. `tx_oe` stays low in every slot until an entry with its enable bit set has been applied.
- R3: Take an applied entry for output lane o, slot k, with the enable bit set and the message bit clear, whose source is lane i, channel j. During slot k, `tx[o]` carries the byte received on `rx[i]` in channel j, and `tx_oe[o]` is high.
- R4: With the constant-delay bit set, a byte received in frame F leaves in frame F+2, whatever the relation between j and k.
- R5: With the constant-delay bit clear, a byte received in frame F leaves in frame F when j < k, and in frame F+1 when j >= k. This includes the case j = k-1, and the case k = 0 with j = CHANNELS-1.
- R6: With the enable bit clear, `tx_oe[o]` is low during slot k only; the neighbouring slots are not affected. `tx_oe` changes only on the first cycle of a slot.
- R7: With the enable bit and the message bit both set, slot k of lane o carries `cfg_msg_byte`. The source fields are then ignored.
- R8: Host writes.
  - A write with `cfg_we` high stores an entry at index `cfg_out_lane`*CHANNELS + `cfg_out_slot`.
  - A write made in any cycle of a frame except its last applies from the next frame onward.
  - The frame in progress keeps the entries that were applied before it.
- R9: The three data pages are written in rotation. The page pointer advances only at a frame start. A constant-delay read never selects the page that is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fp_n | input | 1 | Active-low frame pulse, one cycle wide, marks the cycle before channel 0 |
| rx | input | STREAMS | Serial input lanes |
| tx | output | STREAMS | Serial output lanes (driven low while released) |
| tx_oe | output | STREAMS | Per-lane output enable for the external three-state driver |
| cfg_we | input | 1 | Connection entry write strobe |
| cfg_out_lane | input | log2(STREAMS) | Output lane of the entry |
| cfg_out_slot | input | log2(CHANNELS) | Output slot of the entry |
| cfg_src_lane | input | log2(STREAMS) | Source input lane |
| cfg_src_chan | input | log2(CHANNELS) | Source input channel |
| cfg_const | input | 1 | 1 selects constant delay, 0 selects minimum delay |
| cfg_en | input | 1 | Output enable for the slot |
| cfg_msg | input | 1 | 1 sends `cfg_msg_byte` instead of switched data |
| cfg_msg_byte | input | 8 | Host byte for message mode |

## Verification
The assertions check the cycle-level behaviour on every clock:

- bit pairs stay stable, and the enable changes only at slot boundaries;
- the page pointer holds within a frame and never takes the fourth code;
- applied entries change only at the commit point;
- a minimum-delay read from the page being written only targets channels that have already been stored;
- a constant-delay read never selects that page;
- the lanes stay released until the first enabled entry has been applied.

The bench is needed to show the end-to-end data path. It checks that the right byte arrives from the right lane and channel in the right frame under each delay mode, that message bytes replace the switched data, and that a reprogrammed table leaves the frame in progress untouched.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  localparam int unsigned LANE_FW = 4;
  localparam int unsigned CHAN_FW = 7;

  typedef logic [1:0] page_t;

  typedef struct packed {
    logic [LANE_FW-1:0] src_lane;
    logic [CHAN_FW-1:0] src_chan;
    logic               const_dly;
    logic               out_en;
    logic               msg;
    logic [7:0]         msg_byte;
  } conn_t;

  function automatic page_t page_add(input page_t p, input page_t k);
    logic [2:0] s;
    s = {1'b0, p} + {1'b0, k};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing import tsi_pkg::*; #(
  parameter  int unsigned CHANNELS = 32,
  localparam int unsigned CW       = $clog2(CHANNELS),
  localparam int unsigned CNT_W    = CW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_n,
  output page_t         wr_page,
  output logic [CW-1:0] slot,
  output logic [CW-1:0] next_slot,
  output logic          last_slot,
  output logic [2:0]    bitpos,
  output logic          bit_phase,
  output logic          slot_first,
  output logic          fetch,
  output logic          byte_done,
  output logic          commit
);

  localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(CHANNELS * 16 - 1);
  localparam logic [CW-1:0]    SLOT_LAST  = CW'(CHANNELS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  page_t            page_q, page_d;
  logic             wrap;

  always_comb begin
    wrap   = (~fp_n) | (cnt_q == CNT_LAST);
    cnt_d  = wrap ? '0 : cnt_q + CNT_W'(1);
    page_d = wrap ? page_add(page_q, 2'd1) : page_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      page_q <= page_d;
    end
  end

  always_comb begin
    wr_page    = page_q;
    slot       = cnt_q[CNT_W-1:4];
    last_slot  = (slot == SLOT_LAST);
    next_slot  = last_slot ? '0 : slot + CW'(1);
    bitpos     = cnt_q[3:1];
    bit_phase  = cnt_q[0];
    slot_first = (cnt_q[3:0] == 4'h0);
    fetch      = (cnt_q[3:0] == 4'hF);
    byte_done  = (cnt_q[3:0] == 4'hE);
    commit     = (cnt_q == CNT_LAST - CNT_W'(1));
  end

  p_frame_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_n |=> (cnt_q == '0));

  p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(page_q));

  p_page_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    page_q != 2'd3);

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem import tsi_pkg::*; #(
  parameter  int unsigned STREAMS  = 4,
  parameter  int unsigned CHANNELS = 32,
  localparam int unsigned DEPTH    = STREAMS * CHANNELS,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_idx,
  input  conn_t                       wr_entry,
  input  logic                        commit,
  input  logic [STREAMS-1:0][AW-1:0]  rd_idx,
  output conn_t [STREAMS-1:0]         rd_entry,
  output logic                        any_en
);

  conn_t [DEPTH-1:0] pend_q, pend_d;
  conn_t [DEPTH-1:0] act_q, act_d;

  always_comb begin
    pend_d = pend_q;
    if (wr_en) pend_d[wr_idx] = wr_entry;
    act_d = commit ? pend_d : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  always_comb begin
    for (int r = 0; r < STREAMS; r++) rd_entry[r] = act_q[rd_idx[r]];
    any_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) any_en = any_en | act_q[i].out_en;
  end

  p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_q));

  p_pend_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pend_q[$past(wr_idx)] == $past(wr_entry)));

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem import tsi_pkg::*; #(
  parameter  int unsigned STREAMS  = 4,
  parameter  int unsigned CHANNELS = 32,
  localparam int unsigned SW       = $clog2(STREAMS),
  localparam int unsigned CW       = $clog2(CHANNELS)
) (
  input  logic                        clk,
  input  logic [STREAMS-1:0]          rx,
  input  logic                        sample,
  input  logic                        byte_done,
  input  page_t                       wr_page,
  input  logic [CW-1:0]               wr_chan,
  input  logic [STREAMS-1:0][SW-1:0]  rd_lane,
  input  logic [STREAMS-1:0][CW-1:0]  rd_chan,
  input  page_t [STREAMS-1:0]         rd_page,
  output logic [STREAMS-1:0][7:0]     rd_data
);

  logic [7:0] lane_rd [STREAMS][STREAMS];

  for (genvar s = 0; s < STREAMS; s++) begin : g_lane
    logic [6:0] shift_q;
    logic [7:0] bank_q [3][CHANNELS];

    always_ff @(posedge clk) begin
      if (sample) shift_q <= {shift_q[5:0], rx[s]};
    end

    always_ff @(posedge clk) begin
      if (byte_done) bank_q[wr_page][wr_chan] <= {shift_q, rx[s]};
    end

    for (genvar r = 0; r < STREAMS; r++) begin : g_port
      assign lane_rd[s][r] = bank_q[rd_page[r]][rd_chan[r]];
    end
  end

  always_comb begin
    for (int r = 0; r < STREAMS; r++) begin
      if (({1'b0, rd_lane[r]} < (SW + 1)'(STREAMS)) && (rd_page[r] != 2'd3))
        rd_data[r] = lane_rd[rd_lane[r]][r];
      else
        rd_data[r] = '0;
    end
  end

endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       load_en,
  input  logic [2:0] bitpos,
  input  logic       bit_phase,
  input  logic       slot_first,
  output logic       tx,
  output logic       tx_oe
);

  logic [7:0] byte_q, byte_d;
  logic       oe_q, oe_d;

  always_comb begin
    byte_d = load ? load_byte : byte_q;
    oe_d   = load ? load_en   : oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      byte_q <= byte_d;
      oe_q   <= oe_d;
    end
  end

  assign tx    = oe_q & byte_q[3'd7 - bitpos];
  assign tx_oe = oe_q;

  p_bit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_phase |-> $stable(tx));

  p_oe_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_first |-> $stable(tx_oe));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch import tsi_pkg::*; #(
  parameter  int unsigned STREAMS  = 4,
  parameter  int unsigned CHANNELS = 32,
  localparam int unsigned SW       = $clog2(STREAMS),
  localparam int unsigned CW       = $clog2(CHANNELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fp_n,
  input  logic [STREAMS-1:0] rx,
  output logic [STREAMS-1:0] tx,
  output logic [STREAMS-1:0] tx_oe,
  input  logic               cfg_we,
  input  logic [SW-1:0]      cfg_out_lane,
  input  logic [CW-1:0]      cfg_out_slot,
  input  logic [SW-1:0]      cfg_src_lane,
  input  logic [CW-1:0]      cfg_src_chan,
  input  logic               cfg_const,
  input  logic               cfg_en,
  input  logic               cfg_msg,
  input  logic [7:0]         cfg_msg_byte
);

  localparam int unsigned AW = SW + CW;

  logic rst_meta_q, rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_i      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_i      <= rst_meta_q;
    end
  end

  page_t         wr_page;
  logic [CW-1:0] slot, next_slot;
  logic          last_slot, bit_phase, slot_first, fetch, byte_done, commit;
  logic [2:0]    bitpos;

  tsi_timing #(.CHANNELS(CHANNELS)) i_timing (
    .clk(clk), .rst_n(rst_i), .fp_n(fp_n),
    .wr_page(wr_page), .slot(slot), .next_slot(next_slot), .last_slot(last_slot),
    .bitpos(bitpos), .bit_phase(bit_phase), .slot_first(slot_first),
    .fetch(fetch), .byte_done(byte_done), .commit(commit)
  );

  conn_t                      wr_entry;
  logic [STREAMS-1:0][AW-1:0] rd_idx;
  conn_t [STREAMS-1:0]        rd_entry;
  logic                       any_en;

  always_comb begin
    wr_entry                    = '0;
    wr_entry.src_lane[SW-1:0]   = cfg_src_lane;
    wr_entry.src_chan[CW-1:0]   = cfg_src_chan;
    wr_entry.const_dly          = cfg_const;
    wr_entry.out_en             = cfg_en;
    wr_entry.msg                = cfg_msg;
    wr_entry.msg_byte           = cfg_msg_byte;
  end

  tsi_conn_mem #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) i_conn (
    .clk(clk), .rst_n(rst_i), .wr_en(cfg_we), .wr_idx({cfg_out_lane, cfg_out_slot}),
    .wr_entry(wr_entry), .commit(commit), .rd_idx(rd_idx),
    .rd_entry(rd_entry), .any_en(any_en)
  );

  logic [STREAMS-1:0][SW-1:0] rd_lane;
  logic [STREAMS-1:0][CW-1:0] rd_chan;
  page_t [STREAMS-1:0]        rd_page;
  logic [STREAMS-1:0][7:0]    rd_data;

  tsi_data_mem #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) i_data (
    .clk(clk), .rx(rx), .sample(~bit_phase), .byte_done(byte_done),
    .wr_page(wr_page), .wr_chan(slot),
    .rd_lane(rd_lane), .rd_chan(rd_chan), .rd_page(rd_page), .rd_data(rd_data)
  );

  page_t tgt_page;
  assign tgt_page = last_slot ? page_add(wr_page, 2'd1) : wr_page;

  for (genvar r = 0; r < STREAMS; r++) begin : g_out
    conn_t      ent;
    logic       src_ok;
    logic [7:0] out_byte;

    always_comb begin
      ent        = rd_entry[r];
      rd_idx[r]  = {SW'(r), next_slot};
      rd_lane[r] = ent.src_lane[SW-1:0];
      rd_chan[r] = ent.src_chan[CW-1:0];
      src_ok     = ((ent.src_lane >> SW) == '0) && ((ent.src_chan >> CW) == '0);
      if (ent.const_dly)
        rd_page[r] = page_add(tgt_page, 2'd1);
      else if (rd_chan[r] < next_slot)
        rd_page[r] = tgt_page;
      else
        rd_page[r] = page_add(tgt_page, 2'd2);
      if (ent.msg)       out_byte = ent.msg_byte;
      else if (src_ok)   out_byte = rd_data[r];
      else               out_byte = '0;
    end

    tsi_tx_lane i_tx (
      .clk(clk), .rst_n(rst_i), .load(fetch), .load_byte(out_byte),
      .load_en(ent.out_en), .bitpos(bitpos), .bit_phase(bit_phase),
      .slot_first(slot_first), .tx(tx[r]), .tx_oe(tx_oe[r])
    );

    p_read_after_write_r5: assert property (@(posedge clk) disable iff (!rst_i)
      (fetch && !ent.msg && (rd_page[r] == wr_page) && (next_slot != '0))
        |-> (rd_chan[r] < next_slot));

    p_const_page_r4: assert property (@(posedge clk) disable iff (!rst_i)
      (fetch && ent.const_dly) |-> (rd_page[r] != wr_page));
  end

  logic seen_en_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      seen_en_q <= 1'b0;
    else if (any_en) seen_en_q <= 1'b1;
  end

  p_quiet_until_enabled_r2: assert property (@(posedge clk) disable iff (!rst_i)
    !seen_en_q |-> (tx_oe == '0));

endmodule

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  import tsi_pkg::*;

  localparam int S   = 4;
  localparam int C   = 32;
  localparam int SW  = 2;
  localparam int CW  = 5;
  localparam int LEN = C * 16;

  logic          clk = 1'b0;
  logic          rst_n, fp_n;
  logic [S-1:0]  rx, tx, tx_oe;
  logic          cfg_we, cfg_const, cfg_en, cfg_msg;
  logic [SW-1:0] cfg_out_lane, cfg_src_lane;
  logic [CW-1:0] cfg_out_slot, cfg_src_chan;
  logic [7:0]    cfg_msg_byte;

  always #4 clk = ~clk;

  tsi_switch #(.STREAMS(S), .CHANNELS(C)) i_tsi_switch (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .rx(rx), .tx(tx), .tx_oe(tx_oe),
    .cfg_we(cfg_we), .cfg_out_lane(cfg_out_lane), .cfg_out_slot(cfg_out_slot),
    .cfg_src_lane(cfg_src_lane), .cfg_src_chan(cfg_src_chan), .cfg_const(cfg_const),
    .cfg_en(cfg_en), .cfg_msg(cfg_msg), .cfg_msg_byte(cfg_msg_byte)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    fr       = 0;
  bit    done     = 0;
  conn_t cur_cfg [S*C];
  conn_t pend_cfg[S*C];
  logic [7:0] cap[S];

  function automatic logic [7:0] pat(int f, int s, int c);
    return 8'(f * 29 + s * 67 + c * 13 + 7);
  endfunction

  function automatic conn_t mk(int mode, int os, int oc);
    conn_t e;
    e = '0;
    case (mode)
      1: begin e.src_lane = 4'((os + 1) % S); e.src_chan = 7'((oc * 5 + 3) % C); e.out_en = 1'b1; end
      2: begin e.src_lane = 4'(S - 1 - os); e.src_chan = 7'((oc * 7 + 1) % C);
               e.const_dly = 1'b1; e.out_en = 1'b1; end
      default: begin
        e.src_lane = 4'((os + 2) % S);
        case ((os * C + oc) % 5)
          0: begin e.src_chan = 7'((oc + C - 1) % C); e.out_en = 1'b1; end
          1: begin e.src_chan = 7'(oc); e.out_en = 1'b1; end
          2: begin e.src_chan = 7'((oc + 9) % C); e.const_dly = 1'b1; e.out_en = 1'b1; end
          3: begin e.src_chan = 7'(oc); e.msg = 1'b1; e.out_en = 1'b1;
                   e.msg_byte = 8'(oc * 8 + os) ^ 8'hA5; end
          default: begin e.src_chan = 7'(oc); e.out_en = 1'b0; end
        endcase
      end
    endcase
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s frame %0d: actual %0h expected %0h", tag, fr, act, exp);
    end
  endtask

  task automatic slot_check(input int os, input int oc, input bit r8);
    conn_t e;
    int    sf;
    string pre;
    logic [7:0] exp;
    e   = cur_cfg[os * C + oc];
    pre = r8 ? "R8 " : "";
    if (!e.out_en) begin
      chk(tx_oe[os] == 1'b0, {pre, (fr < 2) ? "R2 oe" : "R6 oe"}, int'(tx_oe[os]), 0);
    end else begin
      chk(tx_oe[os] == 1'b1, {pre, "R3 oe"}, int'(tx_oe[os]), 1);
      if (e.msg) begin
        chk(cap[os] == e.msg_byte, {pre, "R7 msg byte"}, cap[os], e.msg_byte);
      end else begin
        if (e.const_dly)                sf = fr - 2;
        else if (int'(e.src_chan) < oc) sf = fr;
        else                            sf = fr - 1;
        if (sf >= 0) begin
          exp = pat(sf, int'(e.src_lane), int'(e.src_chan));
          if (e.const_dly) chk(cap[os] == exp, {pre, "R4/R9 const byte"}, cap[os], exp);
          else             chk(cap[os] == exp, {pre, "R1/R3/R5 min byte"}, cap[os], exp);
        end
      end
    end
  endtask

  task automatic run_frame(input int mode, input bit r8);
    for (int t = 0; t < LEN; t++) begin
      @(negedge clk);
      fp_n = (t == LEN - 1) ? 1'b0 : 1'b1;
      for (int s = 0; s < S; s++) rx[s] = pat(fr, s, t / 16)[7 - ((t % 16) / 2)];
      if (mode > 0 && t >= 1 && t <= S * C) begin
        conn_t e;
        e = mk(mode, (t - 1) / C, (t - 1) % C);
        pend_cfg[t - 1] = e;
        cfg_we       = 1'b1;
        cfg_out_lane = SW'((t - 1) / C);
        cfg_out_slot = CW'((t - 1) % C);
        cfg_src_lane = e.src_lane[SW-1:0];
        cfg_src_chan = e.src_chan[CW-1:0];
        cfg_const    = e.const_dly;
        cfg_en       = e.out_en;
        cfg_msg      = e.msg;
        cfg_msg_byte = e.msg_byte;
      end else begin
        cfg_we = 1'b0;
      end
      if (t % 2 == 1)
        for (int s = 0; s < S; s++) cap[s][7 - ((t % 16) / 2)] = tx[s];
      if (t % 16 == 15)
        for (int s = 0; s < S; s++) slot_check(s, t / 16, r8);
    end
    fr++;
    cur_cfg = pend_cfg;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < S * C; i++) begin cur_cfg[i] = '0; pend_cfg[i] = '0; end
    rst_n = 1'b0; fp_n = 1'b1; rx = '0; cfg_we = 1'b0;
    cfg_out_lane = '0; cfg_out_slot = '0; cfg_src_lane = '0; cfg_src_chan = '0;
    cfg_const = 1'b0; cfg_en = 1'b0; cfg_msg = 1'b0; cfg_msg_byte = '0;
    repeat (3) @(negedge clk);
    chk(tx_oe == '0, "R2 oe in reset", int'(tx_oe), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(tx_oe == '0, "R2 oe after reset", int'(tx_oe), 0);
    fp_n = 1'b0;
    run_frame(0, 1'b0);
    run_frame(1, 1'b1);
    run_frame(0, 1'b1);
    run_frame(0, 1'b0);
    run_frame(0, 1'b0);
    run_frame(2, 1'b1);
    run_frame(0, 1'b1);
    run_frame(0, 1'b0);
    run_frame(0, 1'b0);
    run_frame(3, 1'b1);
    run_frame(0, 1'b1);
    run_frame(0, 1'b0);
    run_frame(0, 1'b0);
    finish_run();
  end

endmodule